// File: doc/BRIEF.md
# Three-wire serial EEPROM slave

This block behaves like a small serial EEPROM on a three-wire bus. Its storage is a register array of 128 words by 16 bits. A host drives chip select, serial clock and data in. It reads data out through a value pin and an enable pin, and the enable acts as the tri-state control. The block samples all three host pins with a fast system clock, which also times the write cycle.

A command opens with a start bit. A 2-bit opcode follows, then an 8-bit address field. Write-class commands change storage only when the write-enable latch is set. A completed write-class command runs a busy period of `WRITE_CYCLES` system clocks. This period starts when chip select falls. When chip select is raised again, data out shows ready or busy.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset, every word reads 0xFFFF and writes are disabled. While chip select is low, `dout_oe_o` is 0.
- R2: While chip select is high, data in is sampled on each serial clock rise. Zeros before the first 1 are ignored, and that first 1 is the start bit.
- R3: The 2-bit opcode follows the start bit, then an 8-bit field made of one unused bit and A6..A0. The opcodes are 10 read, 01 write and 11 erase. Opcode 00 selects a special command by A6:A5: 11 enable, 00 disable, 01 fill-write and 10 fill-erase.
- R4: For a read, the serial clock rise that samples A0 drives a 0 on data out with the enable high. Each following rise shifts out one of the 16 bits of the addressed word, most significant bit first.
- R5: If clocking continues in a read, the words at the next addresses follow without a gap. The address after 127 is 0.
- R6: A write takes 16 data bits, most significant bit first, after the address and stores them in the addressed word.
- R7: Erase sets the addressed word to 0xFFFF. Fill-erase sets every word to 0xFFFF.
- R8: Fill-write stores its 16 data bits in every word.
- R9: Enable sets the write latch and disable clears it. While the latch is clear, write-class commands change nothing and start no busy period. Reads work in both states.
- R10: A write-class command takes effect only when chip select falls after the command is complete. Dropping chip select earlier discards the command.
- R11: While busy and with chip select high, the block drives 0 on data out and ignores the serial clock. After the busy period it drives 1, until the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for sampling and write timing |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sck_i | input | 1 | Serial clock |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out value |
| dout_oe_o | output | 1 | Drive enable for data out; 0 means high impedance |

## Verification
The assertions assume the host pins change slowly compared with the system clock. Each serial clock level must last several system clocks, so that every edge passes the two-flop synchronizers and is seen exactly once. The bench drives each serial clock phase for six system clocks, on the falling system edge. It changes data in only while the serial clock is low. It changes chip select only while the serial clock is low. It keeps chip select high long enough to watch the whole busy period.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [2:0] {PH_IDLE, PH_OP, PH_ADDR, PH_DATA, PH_READ, PH_HOLD} phase_e;
  typedef enum logic [1:0] {WR_NONE, WR_ONE, WR_ALL} wr_kind_e;
  localparam logic [1:0] OP_SPEC  = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;
  localparam logic [1:0] SEL_WDS  = 2'b00;
  localparam logic [1:0] SEL_WRAL = 2'b01;
  localparam logic [1:0] SEL_ERAL = 2'b10;
  localparam logic [1:0] SEL_WEN  = 2'b11;
endpackage

// File: rtl/uwire_sync.sv
module uwire_sync #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/uwire_array.sv
module uwire_array import uwire_pkg::*; #(
  parameter int AW = 7,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  wr_kind_e      wr_kind_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++)
        if (wr_kind_i == WR_ALL || (wr_kind_i == WR_ONE && waddr_i == AW'(i)))
          mem_q[i] <= wdata_i;
    end
  end
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/uwire_ctrl.sv
module uwire_ctrl import uwire_pkg::*; #(
  parameter int AW = 7,
  parameter int DW = 16,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sck_i,
  input  logic          din_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] raddr_o,
  output wr_kind_e      wr_kind_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          dout_o,
  output logic          dout_oe_o,
  output logic          busy_o,
  output logic          wen_o
);
  localparam int FLD_W = AW + 1;
  localparam int MAXB  = (DW > FLD_W) ? DW : FLD_W;
  localparam int CNT_W = $clog2(MAXB + 1);
  localparam int RI_W  = $clog2(DW);
  localparam int BC_W  = $clog2(WRITE_CYCLES + 1);

  logic sck_q, cs_q;
  logic sck_rise, cs_fall;
  phase_e phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0] op_q;
  logic [FLD_W-1:0] fld_q, fld_next;
  logic [DW-1:0] dat_q, dat_next;
  logic [DW-1:0] rd_sr_q;
  logic [AW-1:0] rd_addr_q;
  logic [RI_W-1:0] rd_idx_q;
  logic dout_q;
  wr_kind_e pend_q;
  logic [AW-1:0] pend_addr_q;
  logic [DW-1:0] pend_data_q;
  logic wen_q, busy_q, status_q;
  logic [BC_W-1:0] bcnt_q;
  logic [AW-1:0] addr_in;
  logic [1:0] sel_in;

  assign sck_rise = sck_i & ~sck_q;
  assign cs_fall  = cs_q & ~cs_i;
  assign fld_next = {fld_q[FLD_W-2:0], din_i};
  assign dat_next = {dat_q[DW-2:0], din_i};
  assign addr_in  = fld_next[AW-1:0];
  assign sel_in   = fld_next[AW-1 -: 2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q <= 1'b0;
      phase_q <= PH_IDLE;
      cnt_q <= '0;
      op_q <= '0;
      fld_q <= '0;
      dat_q <= '0;
      rd_sr_q <= '0;
      rd_addr_q <= '0;
      rd_idx_q <= '0;
      dout_q <= 1'b0;
      pend_q <= WR_NONE;
      pend_addr_q <= '0;
      pend_data_q <= '0;
      wen_q <= 1'b0;
      busy_q <= 1'b0;
      status_q <= 1'b0;
      bcnt_q <= '0;
    end else begin
      sck_q <= sck_i;
      cs_q <= cs_i;
      if (busy_q) begin
        bcnt_q <= bcnt_q - 1'b1;
        if (bcnt_q == BC_W'(1)) busy_q <= 1'b0;
      end
      if (!cs_i) begin
        phase_q <= PH_IDLE;
        pend_q <= WR_NONE;
        if (cs_fall && phase_q == PH_HOLD && pend_q != WR_NONE) begin
          busy_q <= 1'b1;
          bcnt_q <= BC_W'(WRITE_CYCLES);
          status_q <= 1'b1;
        end
      end else if (sck_rise && !busy_q) begin
        case (phase_q)
          PH_IDLE: if (din_i) begin
            phase_q <= PH_OP;
            cnt_q <= '0;
            status_q <= 1'b0;
          end
          PH_OP: begin
            op_q <= {op_q[0], din_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(1)) begin
              phase_q <= PH_ADDR;
              cnt_q <= '0;
            end
          end
          PH_ADDR: begin
            fld_q <= fld_next;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(FLD_W - 1)) begin
              cnt_q <= '0;
              phase_q <= PH_HOLD;
              pend_addr_q <= addr_in;
              case (op_q)
                OP_READ: begin
                  phase_q <= PH_READ;
                  rd_sr_q <= rdata_i;
                  rd_addr_q <= addr_in;
                  rd_idx_q <= '0;
                  dout_q <= 1'b0;
                end
                OP_WRITE: phase_q <= PH_DATA;
                OP_ERASE: if (wen_q) begin
                  pend_q <= WR_ONE;
                  pend_data_q <= '1;
                end
                default: case (sel_in)
                  SEL_WEN:  wen_q <= 1'b1;
                  SEL_WDS:  wen_q <= 1'b0;
                  SEL_WRAL: phase_q <= PH_DATA;
                  default: if (wen_q) begin
                    pend_q <= WR_ALL;
                    pend_data_q <= '1;
                  end
                endcase
              endcase
            end
          end
          PH_DATA: begin
            dat_q <= dat_next;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DW - 1)) begin
              phase_q <= PH_HOLD;
              if (wen_q) begin
                pend_q <= (op_q == OP_WRITE) ? WR_ONE : WR_ALL;
                pend_data_q <= dat_next;
              end
            end
          end
          PH_READ: begin
            dout_q <= rd_sr_q[DW-1];
            rd_sr_q <= {rd_sr_q[DW-2:0], 1'b0};
            rd_idx_q <= rd_idx_q + 1'b1;
            if (rd_idx_q == RI_W'(DW - 1)) begin
              rd_sr_q <= rdata_i;
              rd_addr_q <= rd_addr_q + 1'b1;
              rd_idx_q <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign raddr_o   = (phase_q == PH_READ) ? rd_addr_q + 1'b1 : addr_in;
  assign wr_kind_o = (cs_fall && phase_q == PH_HOLD) ? pend_q : WR_NONE;
  assign waddr_o   = pend_addr_q;
  assign wdata_o   = pend_data_q;
  assign dout_oe_o = cs_i & (status_q | (phase_q == PH_READ));
  assign dout_o    = status_q ? ~busy_q : dout_q;
  assign busy_o    = busy_q;
  assign wen_o     = wen_q;
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom import uwire_pkg::*; #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int WRITE_CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sck_i,
  input  logic din_i,
  output logic dout_o,
  output logic dout_oe_o
);
  logic cs_s, sck_s, din_s;
  logic [ADDR_W-1:0] raddr, waddr;
  logic [DATA_W-1:0] rdata, wdata;
  wr_kind_e wr_kind;
  logic busy, wen;

  uwire_sync #(.W(3)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({cs_i, sck_i, din_i}), .q_o({cs_s, sck_s, din_s})
  );

  uwire_ctrl #(.AW(ADDR_W), .DW(DATA_W), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cs_i(cs_s), .sck_i(sck_s), .din_i(din_s),
    .rdata_i(rdata), .raddr_o(raddr),
    .wr_kind_o(wr_kind), .waddr_o(waddr), .wdata_o(wdata),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o),
    .busy_o(busy), .wen_o(wen)
  );

  uwire_array #(.AW(ADDR_W), .DW(DATA_W)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_kind_i(wr_kind), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(raddr), .rdata_o(rdata)
  );
endmodule

// File: rtl/uwire_eeprom_chk.sv
module uwire_eeprom_chk import uwire_pkg::*; (
  input logic     clk_i,
  input logic     rst_ni,
  input logic     cs_i,
  input logic     cs_s,
  input logic     dout_o,
  input logic     dout_oe_o,
  input wr_kind_e wr_kind,
  input logic     wen,
  input logic     busy
);
  // R1
  oe_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && $past(!cs_i) && $past(!cs_i, 2)) |-> !dout_oe_o);
  // R9
  wr_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind != WR_NONE) |-> wen);
  // R10
  wr_on_cs_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kind != WR_NONE) |-> (!cs_s && $past(cs_s)));
  // R11
  no_wr_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> (wr_kind == WR_NONE));
  // R11
  busy_shows_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && dout_oe_o) |-> !dout_o);
endmodule

bind uwire_eeprom uwire_eeprom_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .cs_s(cs_s),
  .dout_o(dout_o), .dout_oe_o(dout_oe_o),
  .wr_kind(wr_kind), .wen(wen), .busy(busy)
);

// File: tb/uwire_eeprom_test.sv
module uwire_eeprom_test;
  localparam int WC = 300;
  localparam int HALF = 6;
  localparam int WORDS = 128;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sck = 1'b0, din = 1'b0;
  logic dout, oe;
  int n_vec = 0, n_bad = 0;
  logic [15:0] ref_mem [WORDS];
  bit ref_wen = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uwire_eeprom #(.ADDR_W(7), .DATA_W(16), .WRITE_CYCLES(WC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sck_i(sck), .din_i(din),
    .dout_o(dout), .dout_oe_o(oe)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic tick(input logic b, output logic o, output logic e);
    @(negedge clk) din = b;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    o = dout;
    e = oe;
    sck = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic o, e;
    for (int i = n - 1; i >= 0; i--) tick(v[i], o, e);
  endtask

  task automatic open_cs();
    @(negedge clk) cs = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic close_cs();
    @(negedge clk) begin cs = 1'b0; din = 1'b0; end
    repeat (6) @(negedge clk);
    chk("R1 oe released with cs low", {15'd0, oe}, 16'd0);
  endtask

  task automatic head(input logic [1:0] op, input logic [6:0] a);
    send({21'd0, 1'b1, op, 1'b0, a}, 11);
  endtask

  task automatic do_read(input int a, input int nw, input string tag);
    logic o, e;
    logic [15:0] got;
    logic [6:0] a7;
    a7 = 7'(a);
    open_cs();
    send({22'd0, 1'b1, 2'b10, 1'b0, a7[6:1]}, 10);
    tick(a7[0], o, e);
    chk({tag, " R4 dummy enable"}, {15'd0, e}, 16'd1);
    chk({tag, " R4 dummy zero"}, {15'd0, o}, 16'd0);
    for (int w = 0; w < nw; w++) begin
      for (int b = 15; b >= 0; b--) begin
        tick(1'b0, o, e);
        got[b] = o;
      end
      chk(tag, got, ref_mem[(a + w) % WORDS]);
    end
    close_cs();
  endtask

  task automatic finish_wr(input string tag, input bit taken);
    close_cs();
    open_cs();
    if (taken) begin
      chk({tag, " R11 busy enable"}, {15'd0, oe}, 16'd1);
      chk({tag, " R11 busy low"}, {15'd0, dout}, 16'd0);
      repeat (WC + 10) @(negedge clk);
      chk({tag, " R11 ready high"}, {15'd0, dout}, 16'd1);
    end else begin
      chk({tag, " R9 no status"}, {15'd0, oe}, 16'd0);
    end
    close_cs();
  endtask

  task automatic wr_word(input logic [6:0] a, input logic [15:0] d, input string tag);
    open_cs();
    head(2'b01, a);
    send({16'd0, d}, 16);
    if (ref_wen) ref_mem[a] = d;
    finish_wr(tag, ref_wen);
  endtask

  task automatic erase_word(input logic [6:0] a);
    open_cs();
    head(2'b11, a);
    if (ref_wen) ref_mem[a] = 16'hFFFF;
    finish_wr("R7 erase", ref_wen);
  endtask

  task automatic special(input logic [1:0] sel);
    open_cs();
    head(2'b00, {sel, 5'b0});
    close_cs();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic o, e;
    for (int i = 0; i < WORDS; i++) ref_mem[i] = 16'hFFFF;
    repeat (5) @(negedge clk);
    chk("R1 oe low in reset", {15'd0, oe}, 16'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    do_read(5, 1, "R1 reset content");
    wr_word(7'd3, 16'h1234, "R9 write while disabled");
    do_read(3, 1, "R9 disabled write ignored");

    special(2'b11);
    ref_wen = 1'b1;
    wr_word(7'd3, 16'hA5C3, "R6 write");
    wr_word(7'd4, 16'h0F0F, "R6 write");
    wr_word(7'd127, 16'h8001, "R6 write top");
    wr_word(7'd0, 16'h7FFE, "R6 write bottom");
    do_read(3, 2, "R5 increment");
    do_read(127, 2, "R5 wrap");

    // R2 leading zeros
    open_cs();
    send(32'd0, 3);
    head(2'b01, 7'd10);
    send({16'd0, 16'h1357}, 16);
    ref_mem[10] = 16'h1357;
    finish_wr("R2 leading zeros", 1'b1);
    do_read(10, 1, "R2 read back");

    erase_word(7'd4);
    do_read(3, 2, "R7 erase word");

    // R10 abort before completion
    open_cs();
    head(2'b01, 7'd20);
    send({24'd0, 8'h5A}, 8);
    finish_wr("R10 aborted", 1'b0);
    do_read(20, 1, "R10 abort no change");

    // R11 serial clock ignored while busy
    open_cs();
    head(2'b01, 7'd30);
    send({16'd0, 16'hBEEF}, 16);
    ref_mem[30] = 16'hBEEF;
    close_cs();
    open_cs();
    for (int i = 0; i < 11; i++) begin
      tick(i < 2 ? 1'b1 : 1'b0, o, e);
      chk("R11 busy ignores clocks", {14'd0, e, o}, 16'h0002);
    end
    repeat (WC) @(negedge clk);
    chk("R11 ready after busy", {14'd0, oe, dout}, 16'h0003);
    close_cs();
    do_read(30, 1, "R11 busy write kept");

    // R8 fill-write
    open_cs();
    head(2'b00, 7'b01_00000);
    send({16'd0, 16'hC0DE}, 16);
    for (int i = 0; i < WORDS; i++) ref_mem[i] = 16'hC0DE;
    finish_wr("R8 fill-write", 1'b1);
    do_read(0, 1, "R8 fill word 0");
    do_read(77, 1, "R8 fill word 77");

    // R7 fill-erase
    open_cs();
    head(2'b00, 7'b10_00000);
    for (int i = 0; i < WORDS; i++) ref_mem[i] = 16'hFFFF;
    finish_wr("R7 fill-erase", 1'b1);
    do_read(9, 1, "R7 fill-erase read");

    // R3 R9 disable then write ignored
    special(2'b00);
    ref_wen = 1'b0;
    wr_word(7'd9, 16'h1111, "R9 write after disable");
    do_read(9, 1, "R3 disable decoded");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule